// File: doc/BRIEF.md
# Cache Line Fill Buffer with Load Bypass

This block gathers one cache line of eight 32-bit words coming back from an external memory bus. The bus decides the arrival order for each fill. It may start at the requested word and wrap around, or it may run from word 0 up to word 7. Every beat carries its own word address, and the buffer writes each word at that address. Either order therefore ends in the same line.

While a fill is open, loads to the line are answered straight from the buffer for any word that has already arrived. A load to a word that is still missing is held off by keeping its acknowledge low. Stores to the line are merged into the buffer byte by byte. A store byte is never replaced by the memory word that arrives later for the same position. When all eight words are present, the block presents the complete line for one cycle so the data array can take it in a single write. It then accepts a new fill request.

A separate registered pass-through path carries data for loads from non-cacheable memory.

Top module: `line_fill_buf`

## Requirements
- R1: After reset, `fill_ready` is 1, and `line_valid`, `ld_ack` and `unc_out_valid` are 0.
- R2: A fill opens on a clock edge where `fill_req` and `fill_ready` are both 1. `fill_ready` then stays 0 until the cycle after the `line_valid` pulse.
- R3: Each accepted beat writes `beat_data` into word `beat_idx` (word i sits at `line_data[32*i+31:32*i]`). A line filled in wrapping order from any start word gives the same result as a line filled in sequential order from word 0.
- R4: `line_valid` is high for exactly one cycle, the cycle after the edge that registered the last missing word. During that cycle `line_data` holds the complete merged line.
- R5: With `ld_req` high, `ld_ack` is 1 whenever word `ld_idx` has already been registered during the open fill or its transfer cycle. `ld_data` then equals that word, including any store bytes merged into it.
- R6: A load to a word whose beat has not yet been registered sees `ld_ack` 0, even if store bytes for that word are already in the buffer.
- R7: A store (`st_req`) during an open fill updates byte b of word `st_idx` (bits 8b+7:8b) only where `st_be[b]` is 1. The other bytes are unchanged.
- R8: A store byte written before, or in the same cycle as, the memory beat for that word is kept, and the beat supplies only the other bytes.
- R9: Stores made while no fill is open have no effect. A second beat to a word that has already been received is ignored.
- R10: `unc_out_valid` and `unc_out_data` repeat `unc_in_valid` and `unc_in_data` one cycle later, independent of the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_req | input | 1 | Request to open a new line fill |
| fill_ready | output | 1 | Buffer is free to accept a fill |
| beat_valid | input | 1 | Memory beat present |
| beat_idx | input | 3 | Word position of the beat |
| beat_data | input | 32 | Beat data word |
| ld_req | input | 1 | Bypass load request |
| ld_idx | input | 3 | Word addressed by the load |
| ld_ack | output | 1 | Load word available |
| ld_data | output | 32 | Load data from the buffer |
| st_req | input | 1 | Store to the line being filled |
| st_idx | input | 3 | Word addressed by the store |
| st_be | input | 4 | Byte enables of the store |
| st_data | input | 32 | Store data |
| line_valid | output | 1 | Complete line present (one-cycle pulse) |
| line_data | output | 256 | Complete line, word 0 in the low bits |
| unc_in_valid | input | 1 | Non-cacheable load data present |
| unc_in_data | input | 32 | Non-cacheable load data |
| unc_out_valid | output | 1 | Registered non-cacheable valid |
| unc_out_data | output | 32 | Registered non-cacheable data |

## Verification
The properties assume the requester keeps `ld_req` and `ld_idx` steady while it waits for an acknowledge. They also assume the bus sends at most eight distinct word positions per fill. The stimulus raises `fill_req` only when `fill_ready` is expected high, changes the load index only after a check, and drives beats from a list of distinct positions. The one deliberate repeat is a single duplicate beat, used to exercise R9.

// File: rtl/lfb_pkg.sv
package lfb_pkg;
    typedef enum logic [1:0] {
        LF_IDLE = 2'd0,
        LF_FILL = 2'd1,
        LF_XFER = 2'd2
    } lf_state_e;
endpackage

// File: rtl/lfb_word_merge.sv
// Next-value logic for one buffered word: store bytes take priority and stick,
// memory bytes fill only positions no store has claimed.
module lfb_word_merge #(
    parameter int DW = 32,
    localparam int BE = DW / 8
) (
    input  logic [DW-1:0] cur_word,
    input  logic [BE-1:0] cur_mark,
    input  logic          cur_vld,
    input  logic          beat_hit,
    input  logic [DW-1:0] beat_data,
    input  logic          st_hit,
    input  logic [BE-1:0] st_be,
    input  logic [DW-1:0] st_data,
    output logic [DW-1:0] nxt_word,
    output logic [BE-1:0] nxt_mark,
    output logic          nxt_vld
);
    always_comb begin
        nxt_word = cur_word;
        nxt_mark = cur_mark;
        for (int b = 0; b < BE; b++) begin
            if (st_hit && st_be[b]) begin
                nxt_word[8*b +: 8] = st_data[8*b +: 8];
                nxt_mark[b]        = 1'b1;
            end else if (beat_hit && !cur_mark[b]) begin
                nxt_word[8*b +: 8] = beat_data[8*b +: 8];
            end
        end
        nxt_vld = cur_vld | beat_hit;
    end
endmodule

// File: rtl/line_fill_buf.sv
module line_fill_buf
    import lfb_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int DW    = 32,
    localparam int IW   = $clog2(WORDS),
    localparam int BE   = DW / 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fill_req,
    output logic                fill_ready,
    input  logic                beat_valid,
    input  logic [IW-1:0]       beat_idx,
    input  logic [DW-1:0]       beat_data,
    input  logic                ld_req,
    input  logic [IW-1:0]       ld_idx,
    output logic                ld_ack,
    output logic [DW-1:0]       ld_data,
    input  logic                st_req,
    input  logic [IW-1:0]       st_idx,
    input  logic [BE-1:0]       st_be,
    input  logic [DW-1:0]       st_data,
    output logic                line_valid,
    output logic [WORDS*DW-1:0] line_data,
    input  logic                unc_in_valid,
    input  logic [DW-1:0]       unc_in_data,
    output logic                unc_out_valid,
    output logic [DW-1:0]       unc_out_data
);
    typedef struct packed {
        lf_state_e                 st;
        logic [WORDS-1:0][DW-1:0]  buff;
        logic [WORDS-1:0][BE-1:0]  mark;
        logic [WORDS-1:0]          vld;
        logic                      uv;
        logic [DW-1:0]             ud;
    } lfb_reg_t;

    lfb_reg_t q, d;

    logic                     filling;
    logic [WORDS-1:0][DW-1:0] m_word;
    logic [WORDS-1:0][BE-1:0] m_mark;
    logic [WORDS-1:0]         m_vld;

    assign filling = (q.st == LF_FILL);

    // One merge slice per word; position comes from the beat address only.
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        logic beat_hit, st_hit;
        assign beat_hit = filling && beat_valid && (beat_idx == IW'(w)) && !q.vld[w];
        assign st_hit   = filling && st_req && (st_idx == IW'(w));
        lfb_word_merge #(.DW(DW)) u_merge (
            .cur_word (q.buff[w]),
            .cur_mark (q.mark[w]),
            .cur_vld  (q.vld[w]),
            .beat_hit (beat_hit),
            .beat_data(beat_data),
            .st_hit   (st_hit),
            .st_be    (st_be),
            .st_data  (st_data),
            .nxt_word (m_word[w]),
            .nxt_mark (m_mark[w]),
            .nxt_vld  (m_vld[w])
        );
    end

    always_comb begin
        d    = q;
        d.uv = unc_in_valid;
        d.ud = unc_in_data;
        case (q.st)
            LF_IDLE: begin
                if (fill_req) begin
                    d.st   = LF_FILL;
                    d.vld  = '0;
                    d.mark = '0;
                end
            end
            LF_FILL: begin
                d.buff = m_word;
                d.mark = m_mark;
                d.vld  = m_vld;
                if (&m_vld) d.st = LF_XFER;
            end
            LF_XFER: d.st = LF_IDLE;
            default: d.st = LF_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign fill_ready    = (q.st == LF_IDLE);
    assign line_valid    = (q.st == LF_XFER);
    assign line_data     = q.buff;
    assign ld_ack        = ld_req && (q.st != LF_IDLE) && q.vld[ld_idx];
    assign ld_data       = q.buff[ld_idx];
    assign unc_out_valid = q.uv;
    assign unc_out_data  = q.ud;
endmodule

// File: rtl/lfb_checker.sv
module lfb_checker #(
    parameter int DW = 32,
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          fill_req,
    input logic          fill_ready,
    input logic          ld_req,
    input logic [IW-1:0] ld_idx,
    input logic          ld_ack,
    input logic          line_valid,
    input logic          unc_in_valid,
    input logic [DW-1:0] unc_in_data,
    input logic          unc_out_valid,
    input logic [DW-1:0] unc_out_data
);
    p_accept_closes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && fill_ready) |=> !fill_ready);

    p_line_one_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        line_valid |=> (!line_valid && fill_ready));

    p_ack_in_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_ack |-> (ld_req && !fill_ready));

    p_ack_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_ack && !line_valid) |=> (!ld_req || ld_idx != $past(ld_idx) || ld_ack));

    p_unc_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        unc_in_valid |=> (unc_out_valid && unc_out_data == $past(unc_in_data)));

    p_unc_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !unc_in_valid |=> !unc_out_valid);
endmodule

bind line_fill_buf lfb_checker #(.DW(DW), .IW(IW)) u_lfb_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .fill_req     (fill_req),
    .fill_ready   (fill_ready),
    .ld_req       (ld_req),
    .ld_idx       (ld_idx),
    .ld_ack       (ld_ack),
    .line_valid   (line_valid),
    .unc_in_valid (unc_in_valid),
    .unc_in_data  (unc_in_data),
    .unc_out_valid(unc_out_valid),
    .unc_out_data (unc_out_data)
);

// File: tb/line_fill_buf_bench.sv
module line_fill_buf_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS = 8;
    localparam int DW    = 32;
    localparam int NVEC  = 6;
    // Each entry: bit 3 = sequential order, bits 2:0 = first word of the fill.
    localparam logic [3:0] VEC [NVEC] = '{4'b1000, 4'b0000, 4'b0011, 4'b0111, 4'b0101, 4'b0001};

    logic clk = 1'b0, rst_n = 1'b0;
    logic fill_req = 0, beat_valid = 0, ld_req = 0, st_req = 0, unc_in_valid = 0;
    logic [2:0] beat_idx = 0, ld_idx = 0, st_idx = 0;
    logic [3:0] st_be = 0;
    logic [DW-1:0] beat_data = 0, st_data = 0, unc_in_data = 0;
    logic fill_ready, ld_ack, line_valid, unc_out_valid;
    logic [DW-1:0] ld_data, unc_out_data;
    logic [WORDS*DW-1:0] line_data;
    int checks = 0, errors = 0;
    logic [WORDS*DW-1:0] exp_line;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_fill_buf u_line_fill_buf (.*);

    function automatic logic [DW-1:0] wd(input int f, input int i);
        return {8'(f), 8'hA5, 8'h3C, 8'(i)};
    endfunction

    task automatic chk(input string req, input logic [WORDS*DW-1:0] act, input logic [WORDS*DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic open_fill();
        fill_req = 1;
        step();
        fill_req = 0;
    endtask

    task automatic send_beat(input int idx, input logic [DW-1:0] dat);
        beat_valid = 1; beat_idx = 3'(idx); beat_data = dat;
        step();
        beat_valid = 0;
    endtask

    task automatic probe(input string req, input int idx, input logic ack, input logic [DW-1:0] dat);
        ld_req = 1; ld_idx = 3'(idx);
        #1;
        chk(req, {255'd0, ld_ack}, {255'd0, ack});
        if (ack) chk(req, {224'd0, ld_data}, {224'd0, dat});
        ld_req = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", {252'd0, fill_ready, line_valid, ld_ack, unc_out_valid}, {252'd0, 4'b1000});
        rst_n = 1;
        step();

        // R3 R4 R5 R6: table-driven fills in both orders
        for (int v = 0; v < NVEC; v++) begin
            int s;
            s = VEC[v][3] ? 0 : int'(VEC[v][2:0]);
            open_fill();
            chk("R2", {255'd0, fill_ready}, 256'd0);
            for (int k = 0; k < WORDS; k++) begin
                if (k == 4) begin
                    probe("R5", s, 1'b1, wd(v, s));
                    probe("R6", (s + 7) % 8, 1'b0, '0);
                end
                send_beat((s + k) % 8, wd(v, (s + k) % 8));
            end
            for (int i = 0; i < WORDS; i++) exp_line[DW*i +: DW] = wd(v, i);
            chk("R4", {255'd0, line_valid}, 256'd1);
            chk("R3", line_data, exp_line);
            probe("R5", 2, 1'b1, wd(v, 2));
            step();
            chk("R4", {254'd0, line_valid, fill_ready}, 256'd1);
        end

        // R9: store while idle is dropped
        st_req = 1; st_idx = 3; st_be = 4'hF; st_data = 32'hDEAD_BEEF;
        step();
        st_req = 0;
        open_fill();
        // R7 R8: store before beat for word 5
        st_req = 1; st_idx = 5; st_be = 4'b0101; st_data = 32'h1122_3344;
        step();
        st_req = 0;
        probe("R6", 5, 1'b0, '0);
        send_beat(0, wd(9, 0));
        send_beat(1, wd(9, 1));
        // R9: duplicate beat ignored
        send_beat(0, 32'hFFFF_FFFF);
        probe("R9", 0, 1'b1, wd(9, 0));
        // R7: store after beat to word 1
        st_req = 1; st_idx = 1; st_be = 4'b0010; st_data = 32'h0000_AB00;
        step();
        st_req = 0;
        probe("R7", 1, 1'b1, (wd(9, 1) & 32'hFFFF_00FF) | 32'h0000_AB00);
        for (int i = 2; i < 6; i++) send_beat(i, wd(9, i));
        probe("R8", 5, 1'b1, (wd(9, 5) & 32'hFF00_FF00) | 32'h0022_0044);
        // R8: store and beat in the same cycle to word 6
        st_req = 1; st_idx = 6; st_be = 4'b1000; st_data = 32'hEE00_0000;
        send_beat(6, wd(9, 6));
        st_req = 0;
        chk("R2", {255'd0, fill_ready}, 256'd0);
        send_beat(7, wd(9, 7));
        for (int i = 0; i < WORDS; i++) exp_line[DW*i +: DW] = wd(9, i);
        exp_line[DW*1 +: DW] = (wd(9, 1) & 32'hFFFF_00FF) | 32'h0000_AB00;
        exp_line[DW*5 +: DW] = (wd(9, 5) & 32'hFF00_FF00) | 32'h0022_0044;
        exp_line[DW*6 +: DW] = (wd(9, 6) & 32'h00FF_FFFF) | 32'hEE00_0000;
        chk("R4", {255'd0, line_valid}, 256'd1);
        chk("R8", line_data, exp_line);
        step();

        // R10: uncached pass-through
        unc_in_valid = 1; unc_in_data = 32'h5566_7788;
        step();
        unc_in_valid = 0;
        chk("R10", {223'd0, unc_out_valid, unc_out_data}, {223'd0, 1'b1, 32'h5566_7788});
        step();
        chk("R10", {255'd0, unc_out_valid}, 256'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule